// File: doc/BRIEF.md
# Cache Maintenance Range Sequencer

This engine takes one cache-maintenance request and turns it into a series of per-line register writes to a cache controller. A request carries a physical address, a virtual address, a byte count and a two-bit operation code. The engine widens the byte count by the start offset within a line and rounds both addresses down to a line boundary. It then counts the lines covered and issues the commands line by line, one write per clock.

Each line's command carries the virtual index bits that tell cache aliases apart. The `SPLIT_MODE` parameter picks one of two encodings. In the packed encoding, the page-number bits of the virtual address ride in the otherwise unused line-offset bits of the physical address. In the split encoding, each line gets a tag write followed by an index write.

A combined write-back-and-invalidate runs through the invalidate command. Around it, the engine switches the controller's invalidate-mode bit to "write back first" and then switches it back. Any operation that writes data back holds completion until the controller's busy flag drops. The controller itself is outside the block and appears only as a command port and a busy input.

Top module: `cmo_range_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_we` is 0 and `done` is 0.
- R2: Operation codes are 01 (invalidate), 10 (write back) and 11 (write back then invalidate). Codes 01 and 11 use command select 1 (invalidate line), code 10 uses select 2 (write-back line), select 0 is the tag register and select 3 is the mode control register.
- R3: The adjusted size is the request size plus `paddr mod LINE_BYTES`. Both addresses are floored to a line boundary, and the line count is the adjusted size divided by `LINE_BYTES`, rounded up. A line-aligned range of N whole lines issues exactly N line commands.
- R4: With `SPLIT_MODE`=0, each line is a single write whose data is the line-aligned physical address OR-ed with virtual address bits [PAGE_SHIFT+4:PAGE_SHIFT] placed in bits [4:0]. The physical address steps by `LINE_BYTES` per line, and the packed bits stay those of the request.
- R5: With `SPLIT_MODE`=1, each line is a select-0 write of the physical address followed, in the next cycle, by a line write of the virtual address. Both addresses step by `LINE_BYTES` per line.
- R6: For code 11, a select-3 write with data 1 comes before the first line. A select-3 write with data 0 follows once the busy flag has cleared. `done` comes in the cycle after that second write. No other code writes select 3.
- R7: For codes 10 and 11, `done` is withheld until `ctl_busy` is sampled low after the last line command. For code 01, `done` is high in the cycle right after the last line command, whatever `ctl_busy` is.
- R8: A request whose size is exactly one page and whose physical address is page-aligned skips the adjustment. It issues `2**PAGE_SHIFT / LINE_BYTES` lines, and the virtual address is used unrounded.
- R9: A request with size 0 or operation code 00 issues no command, and `done` is high in the cycle after acceptance.
- R10: `req_ready` is 0 from acceptance until `done`, so no request is taken while one is running. `done` is a one-cycle pulse, and at most one command is written per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Engine idle, request accepted when valid |
| req_op | input | 2 | Operation code |
| req_paddr | input | ADDR_W | Physical start address |
| req_vaddr | input | ADDR_W | Virtual start address (cache index source) |
| req_size | input | SIZE_W | Byte count |
| cmd_we | output | 1 | Controller command write strobe |
| cmd_sel | output | 2 | Controller register select |
| cmd_data | output | ADDR_W | Controller command data |
| ctl_busy | input | 1 | Controller write-back in progress |
| done | output | 1 | Request finished (one-cycle pulse) |

## Verification
The bench builds two copies of the engine side by side with 32-byte lines and 8 KB pages. One copy uses the split tag/index encoding and the other uses the packed encoding, and both receive the same request stream. This lets each request be compared under both command layouts. The packed copy sees virtual addresses whose bits 17:13 are all ones or mixed, and the page-sized case issues 256 lines, so the address stepping across a full page is exercised.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

    // controller register select
    typedef enum logic [1:0] {
        SEL_TAG        = 2'd0,
        SEL_INV_LINE   = 2'd1,
        SEL_FLUSH_LINE = 2'd2,
        SEL_CTRL       = 2'd3
    } cmo_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_MODE_ON  = 3'd1,
        ST_TAG      = 3'd2,
        ST_LINE     = 3'd3,
        ST_DRAIN    = 3'd4,
        ST_MODE_OFF = 3'd5
    } cmo_state_e;

    localparam logic [1:0] OP_NONE   = 2'b00;
    localparam logic [1:0] OP_INV    = 2'b01;
    localparam logic [1:0] OP_WB     = 2'b10;
    localparam logic [1:0] OP_WB_INV = 2'b11;

endpackage

// File: rtl/cmo_range_calc.sv
// Line alignment and line-count computation for one request.
module cmo_range_calc #(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int PAGE_SHIFT = 13,
    localparam int LINE_SHIFT = $clog2(LINE_BYTES),
    localparam int CNT_W      = SIZE_W + 1 - LINE_SHIFT
) (
    input  logic [ADDR_W-1:0] paddr,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [SIZE_W-1:0] size,
    output logic [ADDR_W-1:0] paddr_al,
    output logic [ADDR_W-1:0] vaddr_al,
    output logic [CNT_W-1:0]  lines
);
    localparam int PAGE_BYTES = 1 << PAGE_SHIFT;

    logic          page_exact;
    logic [SIZE_W:0] adj_size;
    logic [SIZE_W:0] rnd_size;

    always_comb begin
        page_exact = (size == SIZE_W'(PAGE_BYTES)) &&
                     (paddr[PAGE_SHIFT-1:0] == '0);
        adj_size   = {1'b0, size} + (SIZE_W+1)'(paddr[LINE_SHIFT-1:0]);
        rnd_size   = adj_size + (SIZE_W+1)'(LINE_BYTES - 1);
        if (page_exact) begin
            paddr_al = paddr;
            vaddr_al = vaddr;
            lines    = CNT_W'(PAGE_BYTES / LINE_BYTES);
        end else begin
            paddr_al = {paddr[ADDR_W-1:LINE_SHIFT], {LINE_SHIFT{1'b0}}};
            vaddr_al = {vaddr[ADDR_W-1:LINE_SHIFT], {LINE_SHIFT{1'b0}}};
            lines    = rnd_size[SIZE_W:LINE_SHIFT];
        end
    end

endmodule

// File: rtl/cmo_cmd_gen.sv
// Maps the sequencer state onto one controller register write.
module cmo_cmd_gen
    import cmo_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 13,
    parameter int SPLIT_MODE = 1
) (
    input  cmo_state_e        st,
    input  logic              inv_kind,
    input  logic [ADDR_W-1:0] pa,
    input  logic [ADDR_W-1:0] va,
    output logic              we,
    output cmo_sel_e          sel,
    output logic [ADDR_W-1:0] data
);
    localparam int STUFF_W = 5;

    logic [ADDR_W-1:0] packed_word;

    always_comb begin
        packed_word = pa | ADDR_W'(va[PAGE_SHIFT+STUFF_W-1:PAGE_SHIFT]);
        we   = 1'b0;
        sel  = SEL_TAG;
        data = '0;
        case (st)
            ST_MODE_ON: begin
                we   = 1'b1;
                sel  = SEL_CTRL;
                data = ADDR_W'(1);
            end
            ST_MODE_OFF: begin
                we   = 1'b1;
                sel  = SEL_CTRL;
                data = '0;
            end
            ST_TAG: begin
                we   = 1'b1;
                sel  = SEL_TAG;
                data = pa;
            end
            ST_LINE: begin
                we   = 1'b1;
                sel  = inv_kind ? SEL_INV_LINE : SEL_FLUSH_LINE;
                data = (SPLIT_MODE != 0) ? va : packed_word;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cmo_range_seq.sv
module cmo_range_seq
    import cmo_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int PAGE_SHIFT = 13,
    parameter int SPLIT_MODE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_paddr,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [SIZE_W-1:0] req_size,
    output logic              cmd_we,
    output logic [1:0]        cmd_sel,
    output logic [ADDR_W-1:0] cmd_data,
    input  logic              ctl_busy,
    output logic              done
);
    localparam int LINE_SHIFT = $clog2(LINE_BYTES);
    localparam int CNT_W      = SIZE_W + 1 - LINE_SHIFT;
    localparam cmo_state_e LOOP_ST = (SPLIT_MODE != 0) ? ST_TAG : ST_LINE;

    typedef struct packed {
        cmo_state_e        st;
        logic [1:0]        op;
        logic [ADDR_W-1:0] pa;
        logic [ADDR_W-1:0] va;
        logic [CNT_W-1:0]  left;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [ADDR_W-1:0] calc_pa, calc_va;
    logic [CNT_W-1:0]  calc_lines;
    cmo_sel_e          gen_sel;

    cmo_range_calc #(
        .ADDR_W    (ADDR_W),
        .SIZE_W    (SIZE_W),
        .LINE_BYTES(LINE_BYTES),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) calc_i (
        .paddr   (req_paddr),
        .vaddr   (req_vaddr),
        .size    (req_size),
        .paddr_al(calc_pa),
        .vaddr_al(calc_va),
        .lines   (calc_lines)
    );

    cmo_cmd_gen #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .SPLIT_MODE(SPLIT_MODE)
    ) gen_i (
        .st      (seq_q.st),
        .inv_kind(seq_q.op[0]),
        .pa      (seq_q.pa),
        .va      (seq_q.va),
        .we      (cmd_we),
        .sel     (gen_sel),
        .data    (cmd_data)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.op   = req_op;
                    seq_d.pa   = calc_pa;
                    seq_d.va   = calc_va;
                    seq_d.left = calc_lines;
                    if (req_size == '0 || req_op == OP_NONE) begin
                        seq_d.done = 1'b1;
                    end else if (req_op == OP_WB_INV) begin
                        seq_d.st = ST_MODE_ON;
                    end else begin
                        seq_d.st = LOOP_ST;
                    end
                end
            end
            ST_MODE_ON: seq_d.st = LOOP_ST;
            ST_TAG:     seq_d.st = ST_LINE;
            ST_LINE: begin
                seq_d.pa   = seq_q.pa + ADDR_W'(LINE_BYTES);
                seq_d.va   = (SPLIT_MODE != 0) ? seq_q.va + ADDR_W'(LINE_BYTES) : seq_q.va;
                seq_d.left = seq_q.left - CNT_W'(1);
                if (seq_q.left == CNT_W'(1)) begin
                    if (seq_q.op[1]) begin
                        seq_d.st = ST_DRAIN;
                    end else begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end
                end else begin
                    seq_d.st = LOOP_ST;
                end
            end
            ST_DRAIN: begin
                if (!ctl_busy) begin
                    if (seq_q.op == OP_WB_INV) begin
                        seq_d.st = ST_MODE_OFF;
                    end else begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end
                end
            end
            ST_MODE_OFF: begin
                seq_d.st   = ST_IDLE;
                seq_d.done = 1'b1;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.st == ST_IDLE);
    assign cmd_sel   = gen_sel;
    assign done      = seq_q.done;

endmodule

// File: rtl/cmo_range_seq_chk.sv
module cmo_range_seq_chk #(
    parameter int SIZE_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_op,
    input logic [SIZE_W-1:0] req_size,
    input logic              cmd_we,
    input logic [1:0]        cmd_sel,
    input logic              ctl_busy,
    input logic              done
);
    logic [1:0] op_q;
    logic       nowork_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= 2'b00;
            nowork_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            op_q     <= req_op;
            nowork_q <= (req_size == '0) || (req_op == 2'b00);
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    cmd_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |-> !req_ready);

    // R2
    wb_line_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_sel == 2'd2) |-> (op_q == 2'b10));

    // R2
    inv_line_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_sel == 2'd1) |-> op_q[0]);

    // R6
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_sel == 2'd3) |-> (op_q == 2'b11));

    // R7
    wb_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q[1] && !nowork_q) |-> $past(!ctl_busy));

    // R9
    nowork_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && nowork_q) |-> $past(req_valid && req_ready));

endmodule

bind cmo_range_seq cmo_range_seq_chk #(.SIZE_W(SIZE_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_op   (req_op),
    .req_size (req_size),
    .cmd_we   (cmd_we),
    .cmd_sel  (cmd_sel),
    .ctl_busy (ctl_busy),
    .done     (done)
);

// File: tb/cmo_range_seq_tb_top.sv
`timescale 1ns/1ps
module cmo_range_seq_tb_top;

    localparam int LOGD = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] req_paddr = '0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_size = '0;
    logic        hold_busy = 1'b0;

    logic [1:0]  rdy, we, busy, dn;
    logic [1:0]  sel0, sel1;
    logic [31:0] dat0, dat1;

    int          bcnt [2];
    logic        mode_bit [2];
    int          log_n [2];
    logic [1:0]  log_sel [2][LOGD];
    logic [31:0] log_dat [2][LOGD];
    int          log_cyc [2][LOGD];
    int          done_cnt [2];
    int          done_cyc [2];
    int          acc_cyc;
    int          cyc;

    logic [1:0]  exp_sel [LOGD];
    logic [31:0] exp_dat [LOGD];
    int          exp_n;

    int n_tot;
    int n_bad;

    always #10 clk = ~clk;

    assign busy[0] = (bcnt[0] != 0) || hold_busy;
    assign busy[1] = (bcnt[1] != 0) || hold_busy;

    cmo_range_seq #(.SPLIT_MODE(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[0]),
        .req_op(req_op), .req_paddr(req_paddr), .req_vaddr(req_vaddr),
        .req_size(req_size), .cmd_we(we[0]), .cmd_sel(sel0), .cmd_data(dat0),
        .ctl_busy(busy[0]), .done(dn[0])
    );

    cmo_range_seq #(.SPLIT_MODE(0)) dut_leg_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[1]),
        .req_op(req_op), .req_paddr(req_paddr), .req_vaddr(req_vaddr),
        .req_size(req_size), .cmd_we(we[1]), .cmd_sel(sel1), .cmd_data(dat1),
        .ctl_busy(busy[1]), .done(dn[1])
    );

    initial begin
        cyc = 0;
        acc_cyc = 0;
        for (int k = 0; k < 2; k++) begin
            bcnt[k] = 0; mode_bit[k] = 1'b0; log_n[k] = 0;
            done_cnt[k] = 0; done_cyc[k] = 0;
        end
    end

    // controller model and command capture, away from the active edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (req_valid && rdy[0]) acc_cyc = cyc;
        for (int k = 0; k < 2; k++) begin
            logic [1:0]  s;
            logic [31:0] d;
            s = (k == 0) ? sel0 : sel1;
            d = (k == 0) ? dat0 : dat1;
            if (bcnt[k] > 0) bcnt[k] = bcnt[k] - 1;
            if (we[k]) begin
                if (log_n[k] < LOGD) begin
                    log_sel[k][log_n[k]] = s;
                    log_dat[k][log_n[k]] = d;
                    log_cyc[k][log_n[k]] = cyc;
                end
                log_n[k] = log_n[k] + 1;
                if (s == 2'd2 || (s == 2'd1 && mode_bit[k])) bcnt[k] = 3;
                if (s == 2'd3) mode_bit[k] = d[0];
            end
            if (dn[k]) begin
                done_cnt[k] = done_cnt[k] + 1;
                done_cyc[k] = cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_tot++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic push_exp(input logic [1:0] s, input logic [31:0] d);
        exp_sel[exp_n] = s;
        exp_dat[exp_n] = d;
        exp_n++;
    endtask

    task automatic build_exp(input bit split, input logic [1:0] op,
                             input logic [31:0] pa, input logic [31:0] va,
                             input logic [31:0] size);
        longint      nl;
        logic [31:0] apa, ava, stuff;
        logic [1:0]  lsel;
        exp_n = 0;
        if (size == 0 || op == 2'b00) return;
        if (size == 32'h2000 && pa[12:0] == 13'd0) begin
            apa = pa; ava = va; nl = 256;
        end else begin
            apa = pa & ~32'h1F; ava = va & ~32'h1F;
            nl = (longint'(size) + longint'(pa & 32'h1F) + 31) / 32;
        end
        stuff = (va >> 13) & 32'h1F;
        lsel = op[0] ? 2'd1 : 2'd2;
        if (op == 2'b11) push_exp(2'd3, 32'd1);
        for (int i = 0; i < nl; i++) begin
            if (split) begin
                push_exp(2'd0, apa + 32'(i * 32));
                push_exp(lsel, ava + 32'(i * 32));
            end else begin
                push_exp(lsel, (apa + 32'(i * 32)) | stuff);
            end
        end
        if (op == 2'b11) push_exp(2'd3, 32'd0);
    endtask

    task automatic compare_log(input int k, input string rq, input logic [1:0] op,
                               input logic [31:0] pa, input logic [31:0] va,
                               input logic [31:0] size);
        build_exp(k == 0, op, pa, va, size);
        chk(log_n[k] == exp_n, rq, $sformatf("inst%0d command count", k), log_n[k], exp_n);
        for (int i = 0; i < exp_n && i < log_n[k]; i++) begin
            chk(log_sel[k][i] == exp_sel[i], rq, $sformatf("inst%0d sel[%0d]", k, i),
                log_sel[k][i], exp_sel[i]);
            chk(log_dat[k][i] == exp_dat[i], rq, $sformatf("inst%0d data[%0d]", k, i),
                log_dat[k][i], exp_dat[i]);
        end
    endtask

    function automatic int line_gap(input int k);
        int last;
        last = -1;
        for (int i = 0; i < log_n[k] && i < LOGD; i++)
            if (log_sel[k][i] == 2'd1 || log_sel[k][i] == 2'd2) last = i;
        if (last < 0) return -1;
        return done_cyc[k] - log_cyc[k][last];
    endfunction

    task automatic run_req(input logic [1:0] op, input logic [31:0] pa,
                           input logic [31:0] va, input logic [31:0] size);
        bit work;
        work = (size != 0) && (op != 2'b00);
        @(posedge clk); #1;
        for (int k = 0; k < 2; k++) begin log_n[k] = 0; done_cnt[k] = 0; end
        req_op = op; req_paddr = pa; req_vaddr = va; req_size = size;
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (work) chk(rdy == 2'b00, "R10", "ready low while running", rdy, 0);
        for (int i = 0; i < 3000; i++) begin
            if (done_cnt[0] != 0 && done_cnt[1] != 0) break;
            @(posedge clk);
        end
        repeat (4) @(posedge clk);
        for (int k = 0; k < 2; k++)
            chk(done_cnt[k] == 1, "R10", $sformatf("inst%0d done pulses", k), done_cnt[k], 1);
        chk(rdy == 2'b11, "R10", "ready after done", rdy, 3);
    endtask

    task automatic t_reset;
        chk(rdy == 2'b11, "R1", "ready after reset", rdy, 3);
        chk(we == 2'b00, "R1", "no command after reset", we, 0);
        chk(dn == 2'b00, "R1", "done low after reset", dn, 0);
    endtask

    task automatic t_inv_unaligned;
        hold_busy = 1'b1;
        run_req(2'b01, 32'h1000_0014, 32'h0002_4014, 32'h30);
        hold_busy = 1'b0;
        compare_log(0, "R5", 2'b01, 32'h1000_0014, 32'h0002_4014, 32'h30);
        compare_log(1, "R4", 2'b01, 32'h1000_0014, 32'h0002_4014, 32'h30);
        chk(log_n[1] == 3, "R3", "unaligned range line count", log_n[1], 3);
        chk(log_sel[1][0] == 2'd1, "R2", "invalidate select", log_sel[1][0], 1);
        for (int k = 0; k < 2; k++)
            chk(line_gap(k) == 1, "R7", "invalidate completes without waiting", line_gap(k), 1);
    endtask

    task automatic t_wb_exact_end;
        run_req(2'b10, 32'h2000_0040, 32'h0003_E040, 32'h40);
        compare_log(0, "R5", 2'b10, 32'h2000_0040, 32'h0003_E040, 32'h40);
        compare_log(1, "R4", 2'b10, 32'h2000_0040, 32'h0003_E040, 32'h40);
        chk(log_n[1] == 2, "R3", "aligned range has no extra line", log_n[1], 2);
        chk(log_sel[1][0] == 2'd2, "R2", "write-back select", log_sel[1][0], 2);
        for (int k = 0; k < 2; k++)
            chk(line_gap(k) == 4, "R7", "write-back waits for busy", line_gap(k), 4);
    endtask

    task automatic t_wb_inv;
        run_req(2'b11, 32'h3000_001C, 32'h0001_A01C, 32'h25);
        compare_log(0, "R6", 2'b11, 32'h3000_001C, 32'h0001_A01C, 32'h25);
        compare_log(1, "R6", 2'b11, 32'h3000_001C, 32'h0001_A01C, 32'h25);
        for (int k = 0; k < 2; k++) begin
            chk(line_gap(k) == 5, "R6", "mode restore after busy then done", line_gap(k), 5);
            chk(mode_bit[k] == 1'b0, "R6", "mode bit restored", mode_bit[k], 0);
        end
    endtask

    task automatic t_page;
        run_req(2'b10, 32'h0040_2000, 32'h0006_6004, 32'h2000);
        compare_log(0, "R8", 2'b10, 32'h0040_2000, 32'h0006_6004, 32'h2000);
        compare_log(1, "R8", 2'b10, 32'h0040_2000, 32'h0006_6004, 32'h2000);
        chk(log_dat[0][1] == 32'h0006_6004, "R8", "unrounded first index", log_dat[0][1], 32'h0006_6004);
        run_req(2'b01, 32'h0040_2020, 32'h0006_6024, 32'h2000);
        compare_log(0, "R3", 2'b01, 32'h0040_2020, 32'h0006_6024, 32'h2000);
        compare_log(1, "R3", 2'b01, 32'h0040_2020, 32'h0006_6024, 32'h2000);
        chk(log_dat[0][1] == 32'h0006_6020, "R3", "rounded first index", log_dat[0][1], 32'h0006_6020);
    endtask

    task automatic t_nowork;
        run_req(2'b01, 32'h0000_0004, 32'h0000_0004, 32'h0);
        for (int k = 0; k < 2; k++) begin
            chk(log_n[k] == 0, "R9", "zero size issues nothing", log_n[k], 0);
            chk(done_cyc[k] == acc_cyc + 1, "R9", "zero size done timing", done_cyc[k], acc_cyc + 1);
        end
        run_req(2'b00, 32'h0000_1000, 32'h0000_1000, 32'h40);
        for (int k = 0; k < 2; k++) begin
            chk(log_n[k] == 0, "R9", "code 00 issues nothing", log_n[k], 0);
            chk(done_cyc[k] == acc_cyc + 1, "R9", "code 00 done timing", done_cyc[k], acc_cyc + 1);
        end
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tot++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        n_tot = 0;
        n_bad = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_inv_unaligned();
        t_wb_exact_end();
        t_wb_inv();
        t_page();
        t_nowork();
        finish_run();
    end

endmodule